// File: doc/BRIEF.md
# Protected-Window Write-Quanta Guard with SECDED

This block sits between a system request port and the data path of an ECC-protected DRAM. Software sets one address window as protected. Inside that window, every write must cover exactly one quanta, which is the full memory data word, and must start on a quanta boundary. Such a write reaches memory together with its SECDED check bits. A write that breaks either rule is dropped and raises a write-violation interrupt. The block never turns a partial write into a read-modify-write.

Reads from the protected window are checked against the stored check bits. A single-bit error is corrected in the returned data but stays in memory, so software must repair it. A double-bit error comes back uncorrected and is flagged as an error. Outside the window, any size or alignment is allowed and data passes through unchecked.

Each of the three events (corrected error, uncorrectable error, write violation) has a sticky interrupt flag. The address of the first occurrence since the flag was last cleared is kept alongside it.

Top module: `ecc_quanta_guard`

## Requirements
- R1: The protected window is the half-open range `win_base <= req_addr < win_limit`. When `win_limit <= win_base` the window is disabled and every access is unprotected.
- R2: A protected write with `req_bytes == 4` (one 32-bit quanta) and `req_addr[1:0] == 0` is written to memory in the cycle it is accepted, with all four strobe bits set and the check bits of R6.
- R3: A protected write with any other byte count or alignment leaves memory unwritten. Its response, one cycle later, has `rsp_err = 1`. It sets `irq_flags[2]` (write violation).
- R4: No memory read (`mem_rd_en`) is ever issued while a write request is presented or in flight.
- R5: An unprotected write of any size or offset is written with `mem_wstrb[b] = 1` exactly for byte lanes `b` in `[req_addr[1:0], req_addr[1:0] + req_bytes)`. The write data is lane-positioned and the response has `rsp_err = 0`.
- R6: The check bits are built as follows. Data bit i takes the i-th codeword position from 3 upward that is not a power of two. `mem_wchk[5:0]` is the XOR of the positions of all set data bits. `mem_wchk[6]` makes the XOR of all 32 data bits and all 7 check bits equal to zero.
- R7: On a protected read whose stored word has one flipped bit (data or check), `rsp_rdata` is the corrected data with `rsp_err = 0` and `irq_flags[0]` is set. No memory write is issued.
- R8: On a protected read with two flipped bits, `rsp_rdata` is the stored data unmodified, `rsp_err = 1`, and `irq_flags[1]` is set.
- R9: An unprotected read returns the stored data unmodified and never sets an ECC flag.
- R10: The flags are sticky until a `1` is written to the matching `irq_clr` bit. If a new event and a clear arrive in the same cycle, the flag stays set. `sbe_addr`, `dbe_addr` and `wviol_addr` hold the request address of the first event since that flag was last clear.
- R11: A write's response comes one cycle after acceptance. A read's response comes two cycles after acceptance, because memory returns data one cycle after `mem_rd_en`. `req_ready` is low in the cycle after a read is accepted.
- R12: After reset the flags, captured addresses and `rsp_valid` are zero and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| win_base | input | ADDR_W | First byte address of protected window |
| win_limit | input | ADDR_W | First byte address past protected window |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_bytes | input | 3 | Byte count of a write (1..4) |
| req_wdata | input | 32 | Lane-positioned write data |
| rsp_valid | output | 1 | Response strobe |
| rsp_write | output | 1 | Response belongs to a write |
| rsp_err | output | 1 | Rejected write or uncorrectable read |
| rsp_rdata | output | 32 | Read data (corrected when possible) |
| mem_wr_en | output | 1 | Memory write command |
| mem_rd_en | output | 1 | Memory read command |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_wstrb | output | 4 | Byte lane strobes |
| mem_wchk | output | 7 | Check bits for written word |
| mem_rdata | input | 32 | Stored data, one cycle after read |
| mem_rchk | input | 7 | Stored check bits, one cycle after read |
| irq_clr | input | 3 | Write-one-to-clear for the flags |
| irq_flags | output | 3 | Sticky flags: [0] corrected, [1] uncorrectable, [2] write violation |
| sbe_addr | output | ADDR_W | Address of first corrected error |
| dbe_addr | output | ADDR_W | Address of first uncorrectable error |
| wviol_addr | output | ADDR_W | Address of first rejected write |

## Verification
Some properties are checked on every cycle:
- a rejected write never reaches memory, and no read is issued for a write;
- a protected write carries full strobes, and an unprotected access never counts as a violation;
- the response timing is fixed, and the flags and their captured addresses hold until cleared.

Other behaviour can only be shown by the bench scenarios. These are the check-bit values compared against an independently built codeword, correction of a flipped data or check bit, and raw return on a double flip. They also cover a memory word that stays corrupted after a corrected read, byte merging outside the window, the window edges, and the disabled window.

// File: rtl/ecc_quanta_pkg.sv
package ecc_quanta_pkg;

  localparam int unsigned EQ_DATA_W = 32;

  function automatic int unsigned eq_ham_bits(input int unsigned dw);
    int unsigned r;
    r = 0;
    while ((1 << r) < dw + r + 1) r++;
    return r;
  endfunction

  localparam int unsigned EQ_HAM_W = eq_ham_bits(EQ_DATA_W);
  localparam int unsigned EQ_CHK_W = EQ_HAM_W + 1;
  localparam int unsigned EQ_QB    = EQ_DATA_W / 8;
  localparam int unsigned EQ_QLG   = $clog2(EQ_QB);
  localparam int unsigned EQ_BC_W  = EQ_QLG + 1;
  localparam int unsigned EQ_CW_LEN = EQ_DATA_W + EQ_HAM_W;

  // Codeword position of data bit idx: skip positions that are powers of two.
  function automatic int unsigned eq_data_pos(input int unsigned idx);
    int unsigned cnt;
    int unsigned res;
    cnt = 0;
    res = 0;
    for (int unsigned p = 1; p <= EQ_CW_LEN; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == idx) res = p;
        cnt++;
      end
    end
    return res;
  endfunction

  function automatic logic [EQ_HAM_W-1:0] eq_syndrome(input logic [EQ_DATA_W-1:0] d);
    logic [EQ_HAM_W-1:0] s;
    s = '0;
    for (int unsigned i = 0; i < EQ_DATA_W; i++)
      if (d[i]) s = s ^ EQ_HAM_W'(eq_data_pos(i));
    return s;
  endfunction

  function automatic logic [EQ_CHK_W-1:0] eq_encode(input logic [EQ_DATA_W-1:0] d);
    logic [EQ_HAM_W-1:0] s;
    s = eq_syndrome(d);
    return {(^d) ^ (^s), s};
  endfunction

  // Byte lanes touched by a transfer of nb bytes starting at lane off.
  function automatic logic [EQ_QB-1:0] eq_lane_strobe(input logic [EQ_QLG-1:0] off,
                                                      input logic [EQ_BC_W-1:0] nb);
    logic [EQ_QB-1:0] st;
    for (int b = 0; b < int'(EQ_QB); b++)
      st[b] = (b >= int'(off)) && (b < int'(off) + int'(nb));
    return st;
  endfunction

endpackage

// File: rtl/eqc_window_check.sv
module eqc_window_check
  import ecc_quanta_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [EQ_BC_W-1:0] nbytes,
  input  logic [ADDR_W-1:0]  base,
  input  logic [ADDR_W-1:0]  limit,
  output logic               prot,
  output logic               viol,
  output logic [EQ_QB-1:0]   strobe
);
  logic win_on;
  logic misaligned;
  logic partial;

  assign win_on     = limit > base;
  assign prot       = win_on && (addr >= base) && (addr < limit);
  assign misaligned = addr[EQ_QLG-1:0] != '0;
  assign partial    = nbytes != EQ_BC_W'(EQ_QB);
  assign viol       = prot && (misaligned || partial);
  assign strobe     = eq_lane_strobe(addr[EQ_QLG-1:0], nbytes);
endmodule

// File: rtl/eqc_secded_dec.sv
module eqc_secded_dec
  import ecc_quanta_pkg::*;
(
  input  logic [EQ_DATA_W-1:0] data_in,
  input  logic [EQ_CHK_W-1:0]  chk_in,
  output logic [EQ_DATA_W-1:0] data_out,
  output logic                 single_err,
  output logic                 double_err
);
  logic [EQ_HAM_W-1:0] syn;
  logic                par;
  logic                hit;

  always_comb begin
    syn        = eq_syndrome(data_in) ^ chk_in[EQ_HAM_W-1:0];
    par        = ^{data_in, chk_in};
    data_out   = data_in;
    single_err = 1'b0;
    double_err = 1'b0;
    hit        = 1'b0;
    if (par) begin
      if ((syn & (syn - 1'b1)) == '0) begin
        single_err = 1'b1;          // overall or Hamming check bit flipped
      end else begin
        for (int unsigned i = 0; i < EQ_DATA_W; i++) begin
          if (EQ_HAM_W'(eq_data_pos(i)) == syn) begin
            data_out[i] = ~data_in[i];
            hit         = 1'b1;
          end
        end
        single_err = hit;
        double_err = !hit;
      end
    end else if (syn != '0) begin
      double_err = 1'b1;
    end
  end
endmodule

// File: rtl/eqc_irq_status.sv
module eqc_irq_status #(
  parameter int unsigned NSRC   = 3,
  parameter int unsigned ADDR_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSRC-1:0]          ev_set,
  input  logic [NSRC-1:0]          ev_clr,
  input  logic [NSRC*ADDR_W-1:0]   ev_addr,
  output logic [NSRC-1:0]          flags,
  output logic [NSRC*ADDR_W-1:0]   cap_addr
);
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flags[g]                        <= 1'b0;
        cap_addr[g*ADDR_W +: ADDR_W]    <= '0;
      end else begin
        flags[g] <= ev_set[g] | (flags[g] & ~ev_clr[g]);
        if (ev_set[g] && (!flags[g] || ev_clr[g]))
          cap_addr[g*ADDR_W +: ADDR_W] <= ev_addr[g*ADDR_W +: ADDR_W];
      end
    end

    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[g] && !ev_clr[g]) |=> flags[g]);
    assert_capture_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[g] && !ev_clr[g]) |=> $stable(cap_addr[g*ADDR_W +: ADDR_W]));
  end
endmodule

// File: rtl/ecc_quanta_guard.sv
module ecc_quanta_guard
  import ecc_quanta_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    win_base,
  input  logic [ADDR_W-1:0]    win_limit,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [EQ_BC_W-1:0]   req_bytes,
  input  logic [EQ_DATA_W-1:0] req_wdata,
  output logic                 rsp_valid,
  output logic                 rsp_write,
  output logic                 rsp_err,
  output logic [EQ_DATA_W-1:0] rsp_rdata,
  output logic                 mem_wr_en,
  output logic                 mem_rd_en,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [EQ_DATA_W-1:0] mem_wdata,
  output logic [EQ_QB-1:0]     mem_wstrb,
  output logic [EQ_CHK_W-1:0]  mem_wchk,
  input  logic [EQ_DATA_W-1:0] mem_rdata,
  input  logic [EQ_CHK_W-1:0]  mem_rchk,
  input  logic [2:0]           irq_clr,
  output logic [2:0]           irq_flags,
  output logic [ADDR_W-1:0]    sbe_addr,
  output logic [ADDR_W-1:0]    dbe_addr,
  output logic [ADDR_W-1:0]    wviol_addr
);
  localparam int unsigned NSRC = 3;

  // Named internal events
  logic                 accept;
  logic                 wr_accept;
  logic                 prot;
  logic                 viol;
  logic [EQ_QB-1:0]     lane_strb;
  logic                 rd_pend;
  logic                 rd_prot;
  logic [ADDR_W-1:0]    rd_addr;
  logic [EQ_DATA_W-1:0] fixed_data;
  logic                 dec_single;
  logic                 dec_double;
  logic                 sbe_ev;
  logic                 dbe_ev;
  logic                 wviol_ev;
  logic [NSRC*ADDR_W-1:0] cap_bus;

  eqc_window_check #(.ADDR_W(ADDR_W)) u_win (
    .addr   (req_addr),
    .nbytes (req_bytes),
    .base   (win_base),
    .limit  (win_limit),
    .prot   (prot),
    .viol   (viol),
    .strobe (lane_strb)
  );

  assign req_ready = !rd_pend;
  assign accept    = req_valid && req_ready;
  assign wr_accept = accept && req_write;
  assign wviol_ev  = wr_accept && viol;

  // Memory command side: writes go straight out, never via a read.
  assign mem_wr_en = wr_accept && !viol;
  assign mem_rd_en = accept && !req_write;
  assign mem_addr  = {req_addr[ADDR_W-1:EQ_QLG], EQ_QLG'(0)};
  assign mem_wdata = req_wdata;
  assign mem_wstrb = lane_strb;
  assign mem_wchk  = eq_encode(req_wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend <= 1'b0;
      rd_prot <= 1'b0;
      rd_addr <= '0;
    end else begin
      rd_pend <= mem_rd_en;
      if (mem_rd_en) begin
        rd_prot <= prot;
        rd_addr <= req_addr;
      end
    end
  end

  eqc_secded_dec u_dec (
    .data_in    (mem_rdata),
    .chk_in     (mem_rchk),
    .data_out   (fixed_data),
    .single_err (dec_single),
    .double_err (dec_double)
  );

  assign sbe_ev = rd_pend && rd_prot && dec_single;
  assign dbe_ev = rd_pend && rd_prot && dec_double;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_write <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= wr_accept || rd_pend;
      rsp_write <= wr_accept;
      rsp_err   <= rd_pend ? dbe_ev : wviol_ev;
      rsp_rdata <= rd_pend ? (rd_prot ? fixed_data : mem_rdata) : '0;
    end
  end

  eqc_irq_status #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_set   ({wviol_ev, dbe_ev, sbe_ev}),
    .ev_clr   (irq_clr),
    .ev_addr  ({req_addr, rd_addr, rd_addr}),
    .flags    (irq_flags),
    .cap_addr (cap_bus)
  );

  assign sbe_addr   = cap_bus[0*ADDR_W +: ADDR_W];
  assign dbe_addr   = cap_bus[1*ADDR_W +: ADDR_W];
  assign wviol_addr = cap_bus[2*ADDR_W +: ADDR_W];

  assert_reject_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_accept && viol) |-> !mem_wr_en);
  assert_no_read_for_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |-> !mem_rd_en);
  assert_no_writeback_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pend |-> !mem_wr_en);
  assert_full_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && prot) |-> (&mem_wstrb));
  assert_open_no_viol_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !prot) |-> !viol);
  assert_write_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> (rsp_valid && rsp_write));
  assert_read_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !req_ready);
  assert_unprot_read_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pend && !rd_prot) |=> !$rose(irq_flags[0]) && !$rose(irq_flags[1]));
endmodule

// File: tb/tb_ecc_quanta_guard.sv
`timescale 1ns/1ps
module tb_ecc_quanta_guard;
  localparam int AW = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] win_base = 32'h20;
  logic [31:0] win_limit = 32'h38;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [2:0]  req_bytes = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_write, rsp_err;
  logic [31:0] rsp_rdata;
  logic        mem_wr_en, mem_rd_en;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_wstrb;
  logic [6:0]  mem_wchk;
  logic [31:0] mem_rdata = '0;
  logic [6:0]  mem_rchk = '0;
  logic [2:0]  irq_clr = '0;
  logic [2:0]  irq_flags;
  logic [31:0] sbe_addr, dbe_addr, wviol_addr;

  int checks = 0;
  int fails = 0;
  int wr_cnt = 0;
  int rmw_seen = 0;
  logic [31:0] mem_d [16];
  logic [6:0]  mem_c [16];

  always #10 clk = ~clk;

  ecc_quanta_guard #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .win_base(win_base), .win_limit(win_limit),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_bytes(req_bytes), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_write(rsp_write), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .mem_wr_en(mem_wr_en), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb),
    .mem_wchk(mem_wchk), .mem_rdata(mem_rdata), .mem_rchk(mem_rchk),
    .irq_clr(irq_clr), .irq_flags(irq_flags), .sbe_addr(sbe_addr),
    .dbe_addr(dbe_addr), .wviol_addr(wviol_addr)
  );

  // Memory model: byte-merge writes, one-cycle read latency.
  initial for (int i = 0; i < 16; i++) begin mem_d[i] = '0; mem_c[i] = '0; end
  always @(posedge clk) begin
    if (mem_wr_en) begin
      for (int b = 0; b < 4; b++)
        if (mem_wstrb[b]) mem_d[mem_addr[5:2]][8*b +: 8] = mem_wdata[8*b +: 8];
      mem_c[mem_addr[5:2]] = mem_wchk;
      wr_cnt++;
    end
    if (mem_rd_en) begin
      mem_rdata <= mem_d[mem_addr[5:2]];
      mem_rchk  <= mem_c[mem_addr[5:2]];
    end
  end

  // Reference check bits built from an explicit codeword (R6).
  function automatic logic [6:0] ref_chk(input logic [31:0] d);
    logic [38:0] cw;
    logic [5:0]  h;
    int k;
    cw = '0;
    k = 0;
    for (int p = 1; p <= 38; p++)
      if ((p & (p - 1)) != 0) begin cw[p] = d[k]; k++; end
    for (int b = 0; b < 6; b++) begin
      h[b] = 1'b0;
      for (int p = 1; p <= 38; p++)
        if (((p >> b) & 1) == 1) h[b] = h[b] ^ cw[p];
    end
    return {(^d) ^ (^h), h};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_req(input logic wr, input logic [31:0] a, input logic [2:0] nb,
                        input logic [31:0] d, output logic [31:0] rd,
                        output logic er, output int lat, output logic stall_ok);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_bytes = nb; req_wdata = d;
    while (!req_ready) @(negedge clk);
    if (wr && mem_rd_en) rmw_seen++;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    stall_ok = !req_ready;
    while (!rsp_valid && lat < 6) begin
      if (wr && mem_rd_en) rmw_seen++;
      @(negedge clk);
      lat++;
    end
    rd = rsp_rdata;
    er = rsp_err;
  endtask

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [2:0]  nb;
    logic [31:0] data;
    logic        err;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 32'h20, 3'd4, 32'hA5A51234, 1'b0},
    '{1'b0, 32'h20, 3'd0, 32'hA5A51234, 1'b0},
    '{1'b1, 32'h22, 3'd4, 32'hDEADBEEF, 1'b1},
    '{1'b1, 32'h24, 3'd2, 32'h0000BEEF, 1'b1},
    '{1'b0, 32'h24, 3'd0, 32'h00000000, 1'b0},
    '{1'b1, 32'h04, 3'd4, 32'h11223344, 1'b0},
    '{1'b1, 32'h05, 3'd1, 32'h0000BB00, 1'b0},
    '{1'b0, 32'h04, 3'd0, 32'h1122BB44, 1'b0},
    '{1'b1, 32'h12, 3'd2, 32'hCAFE0000, 1'b0},
    '{1'b0, 32'h10, 3'd0, 32'hCAFE0000, 1'b0},
    '{1'b1, 32'h34, 3'd4, 32'h0F0F0F0F, 1'b0},
    '{1'b1, 32'h38, 3'd2, 32'h00005678, 1'b0},
    '{1'b0, 32'h38, 3'd0, 32'h00005678, 1'b0},
    '{1'b1, 32'h1E, 3'd2, 32'hABCD0000, 1'b0},
    '{1'b0, 32'h1C, 3'd0, 32'hABCD0000, 1'b0}
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    logic er;
    logic stall_ok;
    int lat;
    int wc0;
    string tag;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: reset state
    check("R12 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check("R12 irq_flags", {29'd0, irq_flags}, 32'd0);
    check("R12 captures", sbe_addr | dbe_addr | wviol_addr, 32'd0);
    check("R12 req_ready", {31'd0, req_ready}, 32'd1);

    for (int v = 0; v < NV; v++) begin
      wc0 = wr_cnt;
      do_req(VEC[v].wr, VEC[v].addr, VEC[v].nb, VEC[v].data, rd, er, lat, stall_ok);
      if (VEC[v].wr) begin
        if (VEC[v].err) tag = "R3";
        else if (VEC[v].addr >= 32'h20 && VEC[v].addr < 32'h38) tag = "R2";
        else tag = "R5/R1";
        check({tag, " rsp_err"}, {31'd0, er}, {31'd0, VEC[v].err});
        check({tag, " mem write count"}, wr_cnt - wc0, VEC[v].err ? 0 : 1);
        check("R11 write latency", lat, 1);
      end else begin
        tag = (VEC[v].addr >= 32'h20 && VEC[v].addr < 32'h38) ? "R2 read" : "R9/R1 read";
        check({tag, " data"}, rd, VEC[v].data);
        check({tag, " rsp_err"}, {31'd0, er}, 32'd0);
        check("R11 read latency", lat, 2);
        check("R11 stall after read", {31'd0, stall_ok}, 32'd1);
      end
    end
    check("R3 violation flag", {29'd0, irq_flags}, 32'd4);
    check("R10 first violation addr", wviol_addr, 32'h22);
    check("R6 check bits A", {25'd0, mem_c[8]}, {25'd0, ref_chk(32'hA5A51234)});
    check("R6 check bits B", {25'd0, mem_c[13]}, {25'd0, ref_chk(32'h0F0F0F0F)});
    check("R4 no read on write", rmw_seen, 0);

    // R7: single data-bit flip is corrected, memory stays corrupted
    mem_d[8] = mem_d[8] ^ 32'h20;
    wc0 = wr_cnt;
    do_req(1'b0, 32'h20, 3'd0, 32'h0, rd, er, lat, stall_ok);
    check("R7 corrected data", rd, 32'hA5A51234);
    check("R7 rsp_err", {31'd0, er}, 32'd0);
    check("R7 flags", {29'd0, irq_flags}, 32'd5);
    check("R7 sbe addr", sbe_addr, 32'h20);
    check("R7 no writeback", wr_cnt - wc0, 0);
    check("R7 stored word untouched", mem_d[8], 32'hA5A51214);

    // R7/R10: check-bit flip elsewhere, capture keeps the first address
    mem_c[13] = mem_c[13] ^ 7'h04;
    do_req(1'b0, 32'h34, 3'd0, 32'h0, rd, er, lat, stall_ok);
    check("R7 check-bit flip data", rd, 32'h0F0F0F0F);
    check("R10 sbe addr kept", sbe_addr, 32'h20);

    // R8: double flip returned raw
    mem_d[9] = mem_d[9] ^ 32'h201;
    do_req(1'b0, 32'h24, 3'd0, 32'h0, rd, er, lat, stall_ok);
    check("R8 raw data", rd, 32'h00000201);
    check("R8 rsp_err", {31'd0, er}, 32'd1);
    check("R8 flags", {29'd0, irq_flags}, 32'd7);
    check("R8 dbe addr", dbe_addr, 32'h24);

    // R10: write-one-to-clear on two flags only
    @(negedge clk); irq_clr = 3'b011;
    @(negedge clk); irq_clr = 3'b000;
    check("R10 partial clear", {29'd0, irq_flags}, 32'd4);
    @(negedge clk); irq_clr = 3'b100;
    @(negedge clk); irq_clr = 3'b000;
    check("R10 full clear", {29'd0, irq_flags}, 32'd0);

    // R9: unprotected corrupted word passes raw without flags
    mem_d[1] = mem_d[1] ^ 32'h8;
    do_req(1'b0, 32'h04, 3'd0, 32'h0, rd, er, lat, stall_ok);
    check("R9 raw data", rd, 32'h1122BB4C);
    check("R9 no flags", {29'd0, irq_flags}, 32'd0);

    // R1: disabled window accepts sub-quanta and skips checking
    @(negedge clk); win_limit = 32'h20;
    do_req(1'b1, 32'h22, 3'd2, 32'h77770000, rd, er, lat, stall_ok);
    check("R1 disabled window write", {31'd0, er}, 32'd0);
    do_req(1'b0, 32'h20, 3'd0, 32'h0, rd, er, lat, stall_ok);
    check("R1 disabled window read", rd, 32'h77771214);
    check("R1 disabled window flags", {29'd0, irq_flags}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule